// File: doc/BRIEF.md
# Cursor and Display-Enable Skew Pipeline

This block sits behind the timing core of a character-based video controller. Once per character it takes the current memory address, the scanline-within-row count and the raw display-enable flag. From them it produces two registered outputs: a display enable and a cursor signal. Each output passes through its own programmable delay of zero, one or two characters. This lets the enable and the cursor line up with downstream fetch and character-generation stages that lag the address generator. A delay code of three forces that output low. Software uses that code to blank and unblank the picture mid-frame without touching the timing core.

The cursor fires when the memory address equals the programmed cursor address and the scanline lies inside the programmed start/end window. A two-bit mode field then gates it: steady, off, or following one of two externally supplied blink phases. A light-pen strobe input latches the memory address present on its rising edge. The latched value is held on a read-only output.

Top module: `cursor_skew_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, dispEnOut, cursorOut and penAddr are all zero.
- R2: skewCfg[5:4] selects the display-enable delay. A code of 0, 1 or 2 makes dispEnOut equal the dispEnRaw value sampled that many character steps earlier. A character step is a clock edge with charEn high.
- R3: A display delay code of 3 (skewCfg[5:4]=2'b11) forces dispEnOut low. skewCfg=8'hF0 blanks both outputs. skewCfg=8'hC0 restores display enable with zero delay and keeps the cursor off.
- R4: skewCfg[7:6] selects the cursor delay in the same way: codes 0, 1 and 2 are delays in characters, and code 3 forces cursorOut low.
- R5: The raw cursor condition is memAddr == cursorAddr and curStart[4:0] <= rowAddr <= curEnd. When curStart[4:0] > curEnd, no scanline qualifies.
- R6: curStart[6:5] is the cursor mode. 2'b00 is steady on. 2'b01 is off. 2'b10 gates the cursor with blinkFast. 2'b11 gates it with blinkSlow.
- R7: On any clock edge where lpStrobe is high and was low on the previous edge, penAddr takes memAddr. At every other edge it holds, including while lpStrobe stays high. This does not depend on charEn.
- R8: On clock edges with charEn low, dispEnOut and cursorOut hold their values.
- R9: Both delay lines shift on every character step whatever the selected code. A change of skew code takes effect at the next character step and shows the already-recorded history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charEn | input | 1 | Character step enable |
| memAddr | input | ADDR_W | Current memory address from the timing core |
| rowAddr | input | ROW_W | Scanline within the character row |
| dispEnRaw | input | 1 | Undelayed display enable |
| skewCfg | input | 8 | Skew register: [7:6] cursor delay, [5:4] display delay |
| curStart | input | ROW_W+2 | [6:5] cursor mode, [4:0] first cursor scanline |
| curEnd | input | ROW_W | Last cursor scanline |
| cursorAddr | input | ADDR_W | Cursor memory address |
| blinkFast | input | 1 | Fast blink phase |
| blinkSlow | input | 1 | Slow blink phase |
| lpStrobe | input | 1 | Light-pen strobe |
| dispEnOut | output | 1 | Delayed display enable |
| cursorOut | output | 1 | Delayed cursor |
| penAddr | output | ADDR_W | Latched light-pen address |

## Verification
A corrupted delay-line stage shows up at the ports two character steps after it happens, at the latest, as a misplaced enable or cursor edge. It shows only when the selected code reads that stage. Switching codes mid-stream therefore exposes the stages that a fixed code never reads. A wrong blank decode or mode decode is visible at the very next character step. A bad light-pen edge detector appears one clock after a strobe rises or while the strobe is held high, as a wrong or drifting penAddr.

// File: rtl/skew_pkg.sv
package skew_pkg;
  localparam int SKEW_W = 2;

  typedef enum logic [SKEW_W-1:0] {
    SKEW_ZERO = 2'b00,
    SKEW_ONE  = 2'b01,
    SKEW_TWO  = 2'b10,
    SKEW_OFF  = 2'b11
  } skew_code_e;

  typedef enum logic [1:0] {
    CUR_STEADY = 2'b00,
    CUR_HIDDEN = 2'b01,
    CUR_FAST   = 2'b10,
    CUR_SLOW   = 2'b11
  } cur_mode_e;

  typedef struct packed {
    logic              shiftEn;
    logic [SKEW_W-1:0] dispTap;
    logic              dispOff;
    logic [SKEW_W-1:0] curTap;
    logic              curOff;
    logic              curVisible;
    logic              penCapture;
  } skew_strobe_t;
endpackage

// File: rtl/skew_delay_line.sv
module skew_delay_line #(
  parameter int MAX_SKEW = 2,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftEn,
  input  logic             din,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             forceOff,
  output logic             dout
);
  localparam int TAPS = MAX_SKEW + 1;

  logic [MAX_SKEW-1:0] hist;
  logic [TAPS-1:0]     tapVec;
  logic                tapVal;

  assign tapVec[0] = din;

  generate
    for (genvar i = 0; i < MAX_SKEW; i++) begin : g_stage
      assign tapVec[i+1] = hist[i];
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN)        hist[0] <= 1'b0;
          else if (shiftEn) hist[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN)        hist[i] <= 1'b0;
          else if (shiftEn) hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  always_comb begin
    tapVal = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (tapSel == SEL_W'(i)) tapVal = tapVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        dout <= 1'b0;
    else if (shiftEn) dout <= forceOff ? 1'b0 : tapVal;
  end

  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && forceOff) |=> !dout); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(dout)); // R8
  AST_ZERO_TAP: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn && !forceOff && tapSel == '0) |=> (dout == $past(din))); // R2
endmodule

// File: rtl/skew_ctrl.sv
module skew_ctrl
  import skew_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         charEn,
  input  logic [7:0]   skewCfg,
  input  logic [1:0]   curMode,
  input  logic         blinkFast,
  input  logic         blinkSlow,
  input  logic         lpStrobe,
  output skew_strobe_t strobes
);
  logic       lpPrev;
  skew_code_e dispCode;
  skew_code_e curCode;
  cur_mode_e  modeSel;
  logic       visible;

  always_ff @(posedge clk) begin
    if (!rstN) lpPrev <= 1'b0;
    else       lpPrev <= lpStrobe;
  end

  assign dispCode = skew_code_e'(skewCfg[5:4]);
  assign curCode  = skew_code_e'(skewCfg[7:6]);
  assign modeSel  = cur_mode_e'(curMode);

  always_comb begin
    unique case (modeSel)
      CUR_STEADY: visible = 1'b1;
      CUR_HIDDEN: visible = 1'b0;
      CUR_FAST:   visible = blinkFast;
      CUR_SLOW:   visible = blinkSlow;
      default:    visible = 1'b0;
    endcase
  end

  always_comb begin
    strobes.shiftEn    = charEn;
    strobes.dispTap    = dispCode;
    strobes.dispOff    = (dispCode == SKEW_OFF);
    strobes.curTap     = curCode;
    strobes.curOff     = (curCode == SKEW_OFF);
    strobes.curVisible = visible;
    strobes.penCapture = lpStrobe && !lpPrev;
  end

  AST_PEN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.penCapture |=> !strobes.penCapture); // R7
endmodule

// File: rtl/skew_datapath.sv
module skew_datapath
  import skew_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int ROW_W    = 5,
  parameter int MAX_SKEW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  skew_strobe_t      strobes,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic              dispEnRaw,
  input  logic [ROW_W-1:0]  curFirst,
  input  logic [ROW_W-1:0]  curLast,
  input  logic [ADDR_W-1:0] cursorAddr,
  output logic              dispEnOut,
  output logic              cursorOut,
  output logic [ADDR_W-1:0] penAddr
);
  logic addrHit;
  logic rowHit;
  logic rawCursor;

  assign addrHit   = (memAddr == cursorAddr);
  assign rowHit    = (rowAddr >= curFirst) && (rowAddr <= curLast);
  assign rawCursor = addrHit && rowHit && strobes.curVisible;

  skew_delay_line #(.MAX_SKEW(MAX_SKEW), .SEL_W(SKEW_W)) u_dispLine (
    .clk(clk), .rstN(rstN), .shiftEn(strobes.shiftEn), .din(dispEnRaw),
    .tapSel(strobes.dispTap), .forceOff(strobes.dispOff), .dout(dispEnOut)
  );

  skew_delay_line #(.MAX_SKEW(MAX_SKEW), .SEL_W(SKEW_W)) u_curLine (
    .clk(clk), .rstN(rstN), .shiftEn(strobes.shiftEn), .din(rawCursor),
    .tapSel(strobes.curTap), .forceOff(strobes.curOff), .dout(cursorOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                  penAddr <= '0;
    else if (strobes.penCapture) penAddr <= memAddr;
  end

  AST_PEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.penCapture |=> $stable(penAddr)); // R7
  AST_CURSOR_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shiftEn && strobes.curTap == '0 && memAddr != cursorAddr) |=> !cursorOut); // R5
endmodule

// File: rtl/cursor_skew_unit.sv
module cursor_skew_unit
  import skew_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int ROW_W    = 5,
  parameter int MAX_SKEW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charEn,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic              dispEnRaw,
  input  logic [7:0]        skewCfg,
  input  logic [ROW_W+1:0]  curStart,
  input  logic [ROW_W-1:0]  curEnd,
  input  logic [ADDR_W-1:0] cursorAddr,
  input  logic              blinkFast,
  input  logic              blinkSlow,
  input  logic              lpStrobe,
  output logic              dispEnOut,
  output logic              cursorOut,
  output logic [ADDR_W-1:0] penAddr
);
  skew_strobe_t strobes;

  skew_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .charEn(charEn), .skewCfg(skewCfg),
    .curMode(curStart[ROW_W+1:ROW_W]), .blinkFast(blinkFast),
    .blinkSlow(blinkSlow), .lpStrobe(lpStrobe), .strobes(strobes)
  );

  skew_datapath #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .MAX_SKEW(MAX_SKEW)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memAddr(memAddr),
    .rowAddr(rowAddr), .dispEnRaw(dispEnRaw), .curFirst(curStart[ROW_W-1:0]),
    .curLast(curEnd), .cursorAddr(cursorAddr), .dispEnOut(dispEnOut),
    .cursorOut(cursorOut), .penAddr(penAddr)
  );

  AST_SKEW_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (charEn && skewCfg[7:6] == 2'b11) |=> !cursorOut); // R4
endmodule

// File: tb/cursor_skew_unit_test.sv
module cursor_skew_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        charEn;
  logic [13:0] memAddr;
  logic [4:0]  rowAddr;
  logic        dispEnRaw;
  logic [7:0]  skewCfg;
  logic [6:0]  curStart;
  logic [4:0]  curEnd;
  logic [13:0] cursorAddr;
  logic        blinkFast;
  logic        blinkSlow;
  logic        lpStrobe;
  logic        dispEnOut;
  logic        cursorOut;
  logic [13:0] penAddr;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_skew_unit uut (
    .clk(clk), .rstN(rstN), .charEn(charEn), .memAddr(memAddr),
    .rowAddr(rowAddr), .dispEnRaw(dispEnRaw), .skewCfg(skewCfg),
    .curStart(curStart), .curEnd(curEnd), .cursorAddr(cursorAddr),
    .blinkFast(blinkFast), .blinkSlow(blinkSlow), .lpStrobe(lpStrobe),
    .dispEnOut(dispEnOut), .cursorOut(cursorOut), .penAddr(penAddr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rstN = 1'b0; charEn = 1'b1; memAddr = 14'h123; rowAddr = 5'd3;
    dispEnRaw = 1'b1; skewCfg = 8'h00; curStart = 7'h00; curEnd = 5'd7;
    cursorAddr = 14'h123; blinkFast = 1'b1; blinkSlow = 1'b1; lpStrobe = 1'b1;
    repeat (3) tick();
    chk("R1 disp in reset", {13'd0, dispEnOut}, 14'd0);
    chk("R1 cursor in reset", {13'd0, cursorOut}, 14'd0);
    chk("R1 pen in reset", penAddr, 14'd0);
    lpStrobe = 1'b0; dispEnRaw = 1'b0; memAddr = 14'h000;
    rstN = 1'b1;
    tick();
    chk("R1 disp after reset", {13'd0, dispEnOut}, 14'd0);
    chk("R1 pen after reset", penAddr, 14'd0);
  endtask

  task automatic test_disp_delay(int d);
    logic [7:0] pat = 8'b1011_0010;
    skewCfg = {2'b11, 2'(d), 4'h0};
    dispEnRaw = 1'b0;
    repeat (3) tick();
    for (int k = 0; k < 8; k++) begin
      dispEnRaw = pat[k];
      tick();
      chk($sformatf("R2 disp delay %0d step %0d", d, k), {13'd0, dispEnOut},
          {13'd0, (k >= d) ? pat[k-d] : 1'b0});
    end
  endtask

  task automatic test_cursor_delay(int d);
    logic [7:0] pat = 8'b0110_1001;
    skewCfg = {2'(d), 2'b00, 4'h0};
    curStart = {2'b00, 5'd2}; curEnd = 5'd5; rowAddr = 5'd3;
    cursorAddr = 14'h123; memAddr = 14'h124;
    repeat (3) tick();
    for (int k = 0; k < 8; k++) begin
      memAddr = pat[k] ? 14'h123 : 14'h124;
      tick();
      chk($sformatf("R4 cursor delay %0d step %0d", d, k), {13'd0, cursorOut},
          {13'd0, (k >= d) ? pat[k-d] : 1'b0});
    end
  endtask

  task automatic test_blank();
    memAddr = 14'h123; cursorAddr = 14'h123; rowAddr = 5'd3;
    curStart = {2'b00, 5'd0}; curEnd = 5'd7; dispEnRaw = 1'b1;
    skewCfg = 8'hF0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 F0 blanks disp", {13'd0, dispEnOut}, 14'd0);
      chk("R4 F0 blanks cursor", {13'd0, cursorOut}, 14'd0);
    end
    skewCfg = 8'hC0;
    tick();
    chk("R3 C0 restores disp", {13'd0, dispEnOut}, 14'd1);
    chk("R3 C0 keeps cursor off", {13'd0, cursorOut}, 14'd0);
  endtask

  task automatic cur_case(string req, logic [13:0] a, logic [4:0] r,
                          logic [6:0] s, logic [4:0] e, logic exp);
    memAddr = a; rowAddr = r; curStart = s; curEnd = e;
    tick();
    chk(req, {13'd0, cursorOut}, {13'd0, exp});
  endtask

  task automatic test_cursor_match();
    skewCfg = 8'h00; cursorAddr = 14'h2A5; blinkFast = 1'b1; blinkSlow = 1'b1;
    cur_case("R5 row below start", 14'h2A5, 5'd1, {2'b00, 5'd2}, 5'd5, 1'b0);
    cur_case("R5 row at start",    14'h2A5, 5'd2, {2'b00, 5'd2}, 5'd5, 1'b1);
    cur_case("R5 row at end",      14'h2A5, 5'd5, {2'b00, 5'd2}, 5'd5, 1'b1);
    cur_case("R5 row above end",   14'h2A5, 5'd6, {2'b00, 5'd2}, 5'd5, 1'b0);
    cur_case("R5 start after end", 14'h2A5, 5'd4, {2'b00, 5'd6}, 5'd3, 1'b0);
    cur_case("R5 address off one", 14'h2A4, 5'd3, {2'b00, 5'd2}, 5'd5, 1'b0);
    cur_case("R5 full cell",       14'h2A5, 5'd7, {2'b00, 5'd0}, 5'd7, 1'b1);
  endtask

  task automatic test_modes();
    skewCfg = 8'h00; cursorAddr = 14'h010;
    blinkFast = 1'b1; blinkSlow = 1'b1;
    cur_case("R6 mode off", 14'h010, 5'd3, {2'b01, 5'd0}, 5'd7, 1'b0);
    blinkFast = 1'b1; blinkSlow = 1'b0;
    cur_case("R6 fast phase high", 14'h010, 5'd3, {2'b10, 5'd0}, 5'd7, 1'b1);
    cur_case("R6 slow phase low",  14'h010, 5'd3, {2'b11, 5'd0}, 5'd7, 1'b0);
    blinkFast = 1'b0; blinkSlow = 1'b1;
    cur_case("R6 fast phase low",  14'h010, 5'd3, {2'b10, 5'd0}, 5'd7, 1'b0);
    cur_case("R6 slow phase high", 14'h010, 5'd3, {2'b11, 5'd0}, 5'd7, 1'b1);
    cur_case("R6 steady ignores blink", 14'h010, 5'd3, {2'b00, 5'd0}, 5'd7, 1'b1);
  endtask

  task automatic test_pen();
    charEn = 1'b0; lpStrobe = 1'b0; memAddr = 14'h0AB;
    tick();
    lpStrobe = 1'b1;
    tick();
    chk("R7 capture on rise", penAddr, 14'h0AB);
    memAddr = 14'h155;
    tick();
    chk("R7 held while high", penAddr, 14'h0AB);
    lpStrobe = 1'b0; memAddr = 14'h2AA;
    tick();
    chk("R7 held after fall", penAddr, 14'h0AB);
    lpStrobe = 1'b1;
    tick();
    chk("R7 second rise", penAddr, 14'h2AA);
    lpStrobe = 1'b0; charEn = 1'b1;
    tick();
  endtask

  task automatic test_hold();
    skewCfg = 8'hC0; dispEnRaw = 1'b1;
    tick();
    chk("R8 primed", {13'd0, dispEnOut}, 14'd1);
    charEn = 1'b0; dispEnRaw = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 hold without charEn", {13'd0, dispEnOut}, 14'd1);
    end
    charEn = 1'b1;
    tick();
    chk("R8 resumes", {13'd0, dispEnOut}, 14'd0);
  endtask

  task automatic test_skew_switch();
    logic [7:0] pat = 8'b1100_1010;
    skewCfg = 8'hC0; dispEnRaw = 1'b0;
    repeat (3) tick();
    for (int k = 0; k < 8; k++) begin
      if (k == 4) skewCfg = 8'hE0;
      dispEnRaw = pat[k];
      tick();
      chk($sformatf("R9 switch step %0d", k), {13'd0, dispEnOut},
          {13'd0, (k >= 4) ? pat[k-2] : pat[k]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    test_reset();
    test_disp_delay(0);
    test_disp_delay(1);
    test_disp_delay(2);
    test_blank();
    test_cursor_delay(0);
    test_cursor_delay(1);
    test_cursor_delay(2);
    test_cursor_match();
    test_modes();
    test_pen();
    test_hold();
    test_skew_switch();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule